// File: doc/BRIEF.md
# Flash Program-and-Verify Sequencer

This block sits on the host side of a flash array that takes its commands as bus writes. Given a start address, a word count and a stream of 16-bit data words, it programs the words one after another. For each word it issues a program pulse, which is a setup command followed by a write of the address and data. It then lets the cell settle for a fixed time, switches the flash into verify mode and waits again. Last, it reads the word back and compares it with the data it wrote.

A word that reads back wrong gets another pulse. The number of pulses per word is bounded. The count starts again from zero for every word. When a word still fails after the last allowed pulse, the run stops and the failing address is reported.

Each run ends by returning the flash to read mode. After that the programming-voltage enable drops and a one-cycle done pulse is given. Both wait times are parameters counted in clock cycles. The bus port is a plain request/acknowledge master, so this block can share the flash with an erase sequencer through an external arbiter.

Top module: `fps_prog_seq`

## Requirements
- R1: During and right after reset, `bus_req`, `in_ready`, `vpp_en`, `done` and `error` are all 0.
- R2: A `start` seen while idle latches `base_addr` and `word_count` and raises `vpp_en`. `in_ready` is high only while the sequencer waits for the next word. A new word is taken only after the previous word has verified. A `start` that arrives while a run is in progress has no effect.
- R3: A program pulse is a write of 0040h followed by a write of the data word. Both writes go to the current word's address.
- R4: After the data write is acknowledged, the sequencer idles for `PROG_CYC` cycles and then requests a write of 00C0h. After that write is acknowledged, it idles for `VFY_CYC` cycles and then requests a read of the same address. With a responder that acknowledges one cycle after each request, the 00C0h write comes exactly `PROG_CYC`+2 cycles after the data write, and the read comes exactly `VFY_CYC`+2 cycles after the 00C0h write.
- R5: When the read-back equals the word, the sequencer moves on to the next address (address + 1). The pulse count restarts at zero for the new word.
- R6: When the read-back differs, the sequencer issues a new program pulse. A word that needs N pulses, with N no greater than `MAX_PULSES`, gets exactly N pulses.
- R7: When the word still differs after `MAX_PULSES` pulses, `error` is set and `fail_addr` takes that address. No further words are taken.
- R8: Every run, whether it succeeds or fails, ends with a write of 0000h. After that `vpp_en` goes low and `done` is high for exactly one cycle. No bus request is made while `vpp_en` is low.
- R9: `error` and `fail_addr` keep their values until the next accepted `start`, which clears them.
- R10: Once `bus_req` is raised, it stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack`.
- R11: A run with `word_count` of 0 issues only the 0000h write, ends with `done`, and does not set `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| base_addr | input | AW | First word address |
| word_count | input | LW | Number of words to program |
| in_valid | input | 1 | Data word available |
| in_data | input | 16 | Data word |
| in_ready | output | 1 | Sequencer takes the word this cycle if valid |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | 16 | Write data or command code |
| bus_ack | input | 1 | Transaction complete (read data valid) |
| bus_rdata | input | 16 | Read data |
| vpp_en | output | 1 | Programming-voltage enable, high during a run |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run hit the pulse limit |
| fail_addr | output | AW | Address of the word that failed |

## Verification
The hardest cases to reach are a word that converges on exactly the last allowed pulse and a word that never converges. Both depend on how the flash reacts, not on anything the sequencer drives. The bench therefore models a flash in which each address needs a set number of pulses before its cell takes the data. The pulse counts come from arithmetic patterns that include exactly 25 and 26. A second start pulse injected mid-run and a stalling data stream cover the cases where inputs must be ignored or waited for.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_DATA,
    ST_WPGM,
    ST_VCMD,
    ST_WVFY,
    ST_READ,
    ST_RDMODE
  } fps_state_e;

  localparam logic [WORD_W-1:0] CMD_SETUP  = 16'h0040;
  localparam logic [WORD_W-1:0] CMD_VERIFY = 16'h00C0;
  localparam logic [WORD_W-1:0] CMD_READ   = 16'h0000;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fps_pulse_ctr.sv
module fps_pulse_ctr #(
  parameter int MAX_PULSES = 25,
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          incr,
  output logic [PW-1:0] cnt,
  output logic          at_limit
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | incr;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q == PW'(MAX_PULSES));
endmodule

// File: rtl/fps_addr_gen.sv
module fps_addr_gen #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic          upd_en;

  assign upd_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (upd_en) begin
      addr_q <= load ? base : addr_q + 1'b1;
      left_q <= load ? len  : left_q - 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = (left_q == LW'(1));
endmodule

// File: rtl/fps_prog_seq.sv
module fps_prog_seq
  import fps_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LW         = 16,
  parameter int PROG_CYC   = 2500,
  parameter int VFY_CYC    = 1500,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic [LW-1:0]     word_count,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              vpp_en,
  output logic              done,
  output logic              error,
  output logic [AW-1:0]     fail_addr
);
  localparam int TMAX = (PROG_CYC > VFY_CYC) ? PROG_CYC : VFY_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);

  fps_state_e        state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic              error_q, done_q;
  logic [AW-1:0]     fail_q;

  logic          addr_load, addr_step, addr_last;
  logic [AW-1:0] cur_addr;
  logic          pc_clear, pc_incr, pc_limit;
  logic [PW-1:0] pc_cnt;
  logic          tm_load, tm_run, tm_zero;
  logic [TW-1:0] tm_val;
  logic          word_take, fail_set, done_set, error_clr;

  fps_addr_gen #(.AW(AW), .LW(LW)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .base(base_addr),
    .len(word_count), .step(addr_step), .addr(cur_addr), .last(addr_last)
  );

  fps_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) pulse_i (
    .clk(clk), .rst_n(rst_n), .clear(pc_clear), .incr(pc_incr),
    .cnt(pc_cnt), .at_limit(pc_limit)
  );

  fps_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .run(tm_run), .zero(tm_zero)
  );

  assign tm_run = (state_q == ST_WPGM) || (state_q == ST_WVFY);

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    addr_load = 1'b0;
    addr_step = 1'b0;
    pc_clear  = 1'b0;
    pc_incr   = 1'b0;
    tm_load   = 1'b0;
    tm_val    = '0;
    word_take = 1'b0;
    fail_set  = 1'b0;
    done_set  = 1'b0;
    error_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        addr_load = 1'b1;
        error_clr = 1'b1;
        state_d   = (word_count == '0) ? ST_RDMODE : ST_FETCH;
      end
      ST_FETCH: if (in_valid) begin
        word_take = 1'b1;
        pc_clear  = 1'b1;
        state_d   = ST_SETUP;
      end
      ST_SETUP: if (bus_ack) state_d = ST_DATA;
      ST_DATA: if (bus_ack) begin
        pc_incr = 1'b1;
        tm_load = 1'b1;
        tm_val  = TW'(PROG_CYC - 1);
        state_d = ST_WPGM;
      end
      ST_WPGM: if (tm_zero) state_d = ST_VCMD;
      ST_VCMD: if (bus_ack) begin
        tm_load = 1'b1;
        tm_val  = TW'(VFY_CYC - 1);
        state_d = ST_WVFY;
      end
      ST_WVFY: if (tm_zero) state_d = ST_READ;
      ST_READ: if (bus_ack) begin
        if (bus_rdata == word_q) begin
          addr_step = 1'b1;
          state_d   = addr_last ? ST_RDMODE : ST_FETCH;
        end else if (pc_limit) begin
          fail_set = 1'b1;
          state_d  = ST_RDMODE;
        end else begin
          state_d = ST_SETUP;
        end
      end
      ST_RDMODE: if (bus_ack) begin
        done_set = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (word_take) word_q <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error_q <= 1'b0;
      fail_q  <= '0;
    end else if (error_clr) begin
      error_q <= 1'b0;
      fail_q  <= '0;
    end else if (fail_set) begin
      error_q <= 1'b1;
      fail_q  <= cur_addr;
    end
  end

  // bus and stream outputs
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b1;
    bus_wdata = CMD_READ;
    unique case (state_q)
      ST_SETUP:  begin bus_req = 1'b1; bus_wdata = CMD_SETUP;  end
      ST_DATA:   begin bus_req = 1'b1; bus_wdata = word_q;     end
      ST_VCMD:   begin bus_req = 1'b1; bus_wdata = CMD_VERIFY; end
      ST_READ:   begin bus_req = 1'b1; bus_we    = 1'b0;       end
      ST_RDMODE: begin bus_req = 1'b1; bus_wdata = CMD_READ;   end
      default:   bus_req = 1'b0;
    endcase
  end

  assign bus_addr  = cur_addr;
  assign in_ready  = (state_q == ST_FETCH);
  assign vpp_en    = (state_q != ST_IDLE);
  assign done      = done_q;
  assign error     = error_q;
  assign fail_addr = fail_q;
endmodule

// File: rtl/fps_prog_seq_chk.sv
module fps_prog_seq_chk #(
  parameter int AW         = 16,
  parameter int PW         = 5,
  parameter int MAX_PULSES = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_ready,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          bus_ack,
  input logic          vpp_en,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] fail_addr,
  input logic [PW-1:0] pulse_cnt
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_no_bus_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_en |-> !bus_req);

  assert_done_after_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vpp_en && !bus_req);

  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> vpp_en && !bus_req);

  assert_error_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && $stable(fail_addr));

  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PW'(MAX_PULSES));
endmodule

bind fps_prog_seq fps_prog_seq_chk #(.AW(AW), .PW(PW), .MAX_PULSES(MAX_PULSES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .vpp_en(vpp_en), .done(done),
  .error(error), .fail_addr(fail_addr), .pulse_cnt(pc_cnt)
);

// File: tb/fps_prog_seq_tb_top.sv
`timescale 1ns/1ps
module fps_prog_seq_tb_top;
  localparam int AW = 4, LW = 5, PROG = 6, VFY = 3, MAXP = 25, NW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, in_valid, in_ready, bus_req, bus_we, bus_ack;
  logic vpp_en, done, error;
  logic [AW-1:0] base_addr, bus_addr, fail_addr;
  logic [LW-1:0] word_count;
  logic [15:0]   in_data, bus_wdata, bus_rdata;

  fps_prog_seq #(.AW(AW), .LW(LW), .PROG_CYC(PROG), .VFY_CYC(VFY), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .vpp_en(vpp_en), .done(done), .error(error),
    .fail_addr(fail_addr)
  );

  // flash model: address a takes its data only after need[a] pulses
  int cyc = 0;
  int need [NW];
  int pulses [NW];
  logic [15:0] mem [NW];
  int proto_err, gap_err, mode, t_data, t_vcmd;
  logic armed;
  logic [AW-1:0] setup_a;
  logic [15:0] last_wd;
  int n_cmp = 0, n_bad = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 16'h0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (!vpp_en) proto_err = proto_err + 1;
      if (bus_we) begin
        if (armed) begin
          armed = 1'b0;
          if (bus_addr != setup_a) proto_err = proto_err + 1;
          pulses[bus_addr] = pulses[bus_addr] + 1;
          if (pulses[bus_addr] >= need[bus_addr]) mem[bus_addr] = bus_wdata;
          t_data = cyc;
          mode = 0;
        end else begin
          case (bus_wdata)
            16'h0040: begin armed = 1'b1; setup_a = bus_addr; end
            16'h00C0: begin
              mode = 1;
              if (cyc - t_data != PROG + 2) gap_err = gap_err + 1;
              t_vcmd = cyc;
            end
            16'h0000: mode = 0;
            default:  proto_err = proto_err + 1;
          endcase
        end
        last_wd = bus_wdata;
      end else begin
        if (mode != 1) proto_err = proto_err + 1;
        if (cyc - t_vcmd != VFY + 2) gap_err = gap_err + 1;
        bus_rdata <= mem[bus_addr];
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  function automatic logic [15:0] dat(int s, int i);
    return 16'(32'h5000 + s * 256 + i * 17);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NW; i++) begin
      pulses[i] = 0;
      mem[i] = 16'hFFFF;
    end
    proto_err = 0; gap_err = 0; mode = 0; armed = 1'b0;
    last_wd = 16'hDEAD; t_data = 0; t_vcmd = 0;
  endtask

  task automatic run(int s, int base, int len, bit stall, bit poke);
    int fail_i = -1, accepted = 0, feed = 0, lim;
    bit pend = 1'b0, seen = 1'b0;
    for (int i = 0; i < len; i++)
      if (fail_i < 0 && need[base + i] > MAXP) fail_i = i;
    lim = (fail_i >= 0) ? fail_i + 1 : len;
    clear_model();
    @(negedge clk);
    start = 1'b1; base_addr = AW'(base); word_count = LW'(len);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      if (done) seen = 1'b1;
      if (pend) begin accepted++; feed++; end
      in_valid = !seen && (feed < len) && !(stall && (k % 3 == 1));
      in_data  = dat(s, feed);
      pend     = in_valid && in_ready;
      if (poke && k == 30) begin
        start = 1'b1; base_addr = '0; word_count = LW'(3);
      end else begin
        start = 1'b0;
      end
      if (!seen) @(negedge clk);
    end
    in_valid = 1'b0;
    check($sformatf("R8 s%0d done pulse seen", s), int'(seen), 1);
    check($sformatf("R8 s%0d vpp_en low at done", s), int'(vpp_en), 0);
    check($sformatf("R8 s%0d final write is 0000h", s), int'(last_wd), 0);
    check($sformatf("R7 s%0d error flag", s), int'(error), int'(fail_i >= 0));
    if (fail_i >= 0)
      check($sformatf("R7 s%0d fail_addr", s), int'(fail_addr), base + fail_i);
    check($sformatf("R2 s%0d words taken", s), accepted, lim);
    check($sformatf("R3 s%0d command sequence errors", s), proto_err, 0);
    check($sformatf("R4 s%0d wait-time errors", s), gap_err, 0);
    for (int a = 0; a < NW; a++) begin
      int ep = 0;
      logic [15:0] em = 16'hFFFF;
      if (a >= base && a < base + lim) begin
        ep = (need[a] < MAXP) ? need[a] : MAXP;
        if (!(fail_i >= 0 && a == base + fail_i)) em = dat(s, a - base);
      end
      check($sformatf("R6 s%0d pulses at addr %0d", s, a), pulses[a], ep);
      check($sformatf("R5 s%0d content at addr %0d", s, a), int'(mem[a]), int'(em));
    end
    @(negedge clk);
    check($sformatf("R8 s%0d done lasts one cycle", s), int'(done), 0);
  endtask

  initial begin
    #760000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
    base_addr = '0; word_count = '0;
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 reset bus_req", int'(bus_req), 0);
    check("R1 reset in_ready", int'(in_ready), 0);
    check("R1 reset vpp_en", int'(vpp_en), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset error", int'(error), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release vpp_en", int'(vpp_en), 0);

    // S1: every word takes on the first pulse, stalling stream
    for (int i = 0; i < NW; i++) need[i] = 1;
    run(1, 2, 6, 1'b1, 1'b0);

    // S2: full array, pulse needs sweep 1..25 (address 9 needs exactly 25)
    for (int i = 0; i < NW; i++) need[i] = 1 + (i * 11) % 25;
    run(2, 0, 16, 1'b0, 1'b0);

    // S3: address 8 needs 26 pulses -> error after 25
    for (int i = 0; i < NW; i++) need[i] = 1 + (i % 3);
    need[8] = 26;
    run(3, 5, 6, 1'b0, 1'b0);

    // R9: error and failing address held while idle
    repeat (10) @(negedge clk);
    check("R9 error held while idle", int'(error), 1);
    check("R9 fail_addr held while idle", int'(fail_addr), 8);

    // S4: zero-length run, clears the old error (R11)
    run(4, 7, 0, 1'b0, 1'b0);
    check("R11 zero-length run clears error", int'(error), 0);

    // S5: start pulse mid-run must be ignored
    for (int i = 0; i < NW; i++) need[i] = 2;
    run(5, 12, 4, 1'b1, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule